// File: doc/BRIEF.md
# Misaligned Load Splitter with Trap Reporting

This block takes scalar integer load commands of 2, 4 or 8 bytes and serves them through a memory request port whose addresses are translated in two stages. A naturally aligned load goes out as one request of the full size. A load that is not aligned is broken into single-byte reads. The reads start at the original address and go upward one byte at a time. The returned bytes are packed little-endian into a 64-bit result, which is zero- or sign-extended.

If a byte read comes back with a fault, the block stops at once and reports a trap. The trap carries:
- the cause code from the memory side,
- the virtual address of the byte that faulted,
- the faulting guest-physical address shifted right by two,
- a transformed load instruction word that keeps the original access width and records how far the faulting byte lies above the original address.

A self-check output rebuilds the original guest-physical address from these trap values. Because bytes are read in rising order, the lower fault always wins when an access straddles two faulting pages. A trap handler can then tell a misaligned access apart from a plain access that begins on a page boundary.

Top module: `mls_top`

## Requirements
- R1: After reset, cmd_ready is 1 and mem_req_valid, res_valid and trap_valid are 0.
- R2: A command whose address is a multiple of its byte count produces exactly one request at that address, with mem_req_size = width code + 1 (1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). Width code 0 means 2 bytes, 1 means 4 bytes and 2 means 8 bytes.
- R3: A command that is not aligned produces single-byte requests (mem_req_size = 0) at addresses original, original+1, and so on, strictly rising.
- R4: Without a fault, res_data holds byte (original+i) in bits 8i+7:8i. Bits above the access are zero when cmd_signed = 0, and are copies of the top byte's bit 7 when cmd_signed = 1.
- R5: After a faulting response, no further request is issued for that command.
- R6: The trap reports the first faulting byte in address order, so the lower page wins when both pages fault. trap_tval is that byte's virtual address and trap_cause is the cause code returned with the fault.
- R7: trap_tval2 equals the faulting guest-physical address shifted right by two bits.
- R8: trap_tinst has these fields: opcode 0x03 in bits 6:0, the destination register in bits 11:7, funct3 = {unsigned flag, width code + 1} in bits 14:12, and (faulting address − original address) in bits 19:15. All other bits are zero.
- R9: chk_addr equals (trap_tval2 << 2) + trap_tval[1:0] − offset, which is the original access's guest-physical address.
- R10: Each accepted command yields exactly one one-cycle pulse, either on res_valid or on trap_valid. cmd_ready stays 0 until that pulse.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, the request stays asserted with a stable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Load command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_vaddr | input | VA_W | Original virtual address |
| cmd_width | input | 2 | Width code: 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes |
| cmd_signed | input | 1 | Sign-extend the result |
| cmd_rd | input | 5 | Destination register index |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | VA_W | Request virtual address |
| mem_req_size | output | 2 | log2 of request byte count |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | DATA_W | Read data, low bytes first |
| mem_rsp_fault | input | 1 | Request faulted |
| mem_rsp_cause | input | 6 | Cause code of the fault |
| mem_rsp_gpa | input | GPA_W | Guest-physical address of the faulting byte |
| res_valid | output | 1 | Result pulse |
| res_data | output | DATA_W | Assembled, extended load value |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 6 | Reported cause |
| trap_tval | output | VA_W | Faulting virtual address |
| trap_tval2 | output | GPA_W | Faulting guest-physical address >> 2 |
| trap_tinst | output | 32 | Transformed load instruction |
| chk_addr | output | GPA_W | Recovered original guest-physical address |

## Verification
The assertions assume a well-behaved memory side. It returns exactly one response for each accepted request, and never a response while no request is outstanding. The bench's responder answers one cycle after each handshake and then drops mem_rsp_valid. It also stalls mem_req_ready every third cycle. Commands use only width codes 0 to 2. The guest-physical mapping is kept contiguous, with page offsets preserved, so the recovered address is well defined. The start address sweeps across a page boundary under four fault patterns: no fault, upper page only, both pages, and lower page only.

// File: rtl/mls_pkg.sv
package mls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } mls_state_e;

    localparam logic [6:0] OPC_LOAD  = 7'h03;
    localparam int         OFF_BITS  = 5;
    localparam int         CAUSE_W   = 6;
    localparam logic [1:0] WIDTH_MAX = 2'd2;
endpackage

// File: rtl/mls_assemble.sv
module mls_assemble #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              sgn,
    output logic [DATA_W-1:0] value
);
    localparam int LANES = DATA_W / 8;

    logic fill;
    assign fill = sgn & acc[{last_idx, 3'b111}];

    genvar b;
    generate
        for (b = 0; b < LANES; b++) begin : g_lane
            assign value[b*8 +: 8] = (IDX_W'(b) <= last_idx) ? acc[b*8 +: 8] : {8{fill}};
        end
    endgenerate
endmodule

// File: rtl/mls_trap_fmt.sv
module mls_trap_fmt #(
    parameter int GPA_W = 32,
    parameter int IDX_W = 3
) (
    input  logic [GPA_W-1:0] gpa,
    input  logic [1:0]       tval_lo,
    input  logic [IDX_W-1:0] off,
    input  logic [4:0]       rd,
    input  logic [1:0]       wcode,
    input  logic             sgn,
    output logic [GPA_W-1:0] tval2,
    output logic [31:0]      tinst,
    output logic [GPA_W-1:0] chk
);
    import mls_pkg::*;

    logic [2:0] funct3;
    logic [1:0] size_code;

    assign size_code = wcode + 2'd1;
    assign funct3    = {~sgn, size_code};
    assign tval2     = gpa >> 2;
    assign tinst     = {12'b0, OFF_BITS'(off), funct3, rd, OPC_LOAD};
    assign chk       = (tval2 << 2) + GPA_W'(tval_lo) - GPA_W'(off);
endmodule

// File: rtl/mls_top.sv
module mls_top #(
    parameter int VA_W   = 32,
    parameter int GPA_W  = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [VA_W-1:0]   cmd_vaddr,
    input  logic [1:0]        cmd_width,
    input  logic              cmd_signed,
    input  logic [4:0]        cmd_rd,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_fault,
    input  logic [5:0]        mem_rsp_cause,
    input  logic [GPA_W-1:0]  mem_rsp_gpa,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              trap_valid,
    output logic [5:0]        trap_cause,
    output logic [VA_W-1:0]   trap_tval,
    output logic [GPA_W-1:0]  trap_tval2,
    output logic [31:0]       trap_tinst,
    output logic [GPA_W-1:0]  chk_addr
);
    import mls_pkg::*;

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    typedef struct packed {
        mls_state_e        st;
        logic [VA_W-1:0]   base;
        logic [1:0]        wcode;
        logic              sgn;
        logic [4:0]        rd;
        logic              byte_mode;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] acc;
        logic              res_v;
        logic              trap_v;
        logic [5:0]        cause;
        logic [VA_W-1:0]   tval;
        logic [GPA_W-1:0]  gpa;
        logic [IDX_W-1:0]  off;
    } ctl_t;

    ctl_t q, d;

    logic [1:0]       cmd_w_eff;
    logic [IDX_W-1:0] cmd_last;
    logic [IDX_W-1:0] cur_last;
    logic             cmd_misaligned;
    logic [VA_W-1:0]  cur_addr;

    assign cmd_w_eff      = (cmd_width > WIDTH_MAX) ? WIDTH_MAX : cmd_width;
    assign cmd_last       = IDX_W'((32'd2 << cmd_w_eff) - 32'd1);
    assign cur_last       = IDX_W'((32'd2 << q.wcode) - 32'd1);
    assign cmd_misaligned = |(cmd_vaddr[IDX_W-1:0] & cmd_last);
    assign cur_addr       = q.byte_mode ? (q.base + VA_W'(q.idx)) : q.base;

    always_comb begin
        d        = q;
        d.res_v  = 1'b0;
        d.trap_v = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st        = ST_REQ;
                    d.base      = cmd_vaddr;
                    d.wcode     = cmd_w_eff;
                    d.sgn       = cmd_signed;
                    d.rd        = cmd_rd;
                    d.byte_mode = cmd_misaligned;
                    d.idx       = '0;
                    d.acc       = '0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        d.st     = ST_IDLE;
                        d.trap_v = 1'b1;
                        d.cause  = mem_rsp_cause;
                        d.tval   = cur_addr;
                        d.gpa    = mem_rsp_gpa;
                        d.off    = q.idx;
                    end else if (q.byte_mode) begin
                        for (int b = 0; b < LANES; b++) begin
                            if (IDX_W'(b) == q.idx) begin
                                d.acc[b*8 +: 8] = mem_rsp_data[7:0];
                            end
                        end
                        if (q.idx == cur_last) begin
                            d.st    = ST_IDLE;
                            d.res_v = 1'b1;
                        end else begin
                            d.idx = q.idx + 1'b1;
                            d.st  = ST_REQ;
                        end
                    end else begin
                        d.acc   = mem_rsp_data;
                        d.st    = ST_IDLE;
                        d.res_v = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_REQ);
    assign mem_req_addr  = cur_addr;
    assign mem_req_size  = q.byte_mode ? 2'd0 : (q.wcode + 2'd1);
    assign res_valid     = q.res_v;
    assign trap_valid    = q.trap_v;
    assign trap_cause    = q.cause;
    assign trap_tval     = q.tval;

    mls_assemble #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
        .acc      (q.acc),
        .last_idx (cur_last),
        .sgn      (q.sgn),
        .value    (res_data)
    );

    mls_trap_fmt #(.GPA_W(GPA_W), .IDX_W(IDX_W)) u_fmt (
        .gpa     (q.gpa),
        .tval_lo (q.tval[1:0]),
        .off     (q.off),
        .rd      (q.rd),
        .wcode   (q.wcode),
        .sgn     (q.sgn),
        .tval2   (trap_tval2),
        .tinst   (trap_tinst),
        .chk     (chk_addr)
    );

    // Checker state: last byte request address within the current command
    logic [VA_W-1:0] prev_addr_q;
    logic            prev_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
            prev_ok_q   <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            prev_ok_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && mem_req_size == 2'd0) begin
            prev_addr_q <= mem_req_addr;
            prev_ok_q   <= 1'b1;
        end
    end

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_size == 2'd0 && prev_ok_q)
        |-> (mem_req_addr == prev_addr_q + 1'b1));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || trap_valid) |-> ($past(mem_rsp_valid) && !(res_valid && trap_valid)));

    assert_trap_from_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $past(mem_rsp_fault));

    assert_no_req_after_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (!mem_req_valid && cmd_ready));

    assert_rsp_solicited_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (q.st == ST_WAIT));
endmodule

// File: tb/tb_mls_top.sv
`timescale 1ns/1ps
module tb_mls_top;
    localparam int VA_W = 32, GPA_W = 32, DATA_W = 64;
    localparam logic [31:0] GPA_OFS = 32'h0004_0000;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_signed = 0;
    logic [VA_W-1:0] cmd_vaddr = '0;
    logic [1:0] cmd_width = '0;
    logic [4:0] cmd_rd = '0;
    logic cmd_ready, mem_req_valid, res_valid, trap_valid;
    logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_fault = 0;
    logic [VA_W-1:0] mem_req_addr, trap_tval;
    logic [1:0] mem_req_size;
    logic [DATA_W-1:0] mem_rsp_data = '0, res_data;
    logic [5:0] mem_rsp_cause = '0, trap_cause;
    logic [GPA_W-1:0] mem_rsp_gpa = '0, trap_tval2, chk_addr;
    logic [31:0] trap_tinst;

    always #2.5 clk = ~clk;

    mls_top #(.VA_W(VA_W), .GPA_W(GPA_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vaddr(cmd_vaddr), .cmd_width(cmd_width), .cmd_signed(cmd_signed), .cmd_rd(cmd_rd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
        .mem_rsp_cause(mem_rsp_cause), .mem_rsp_gpa(mem_rsp_gpa),
        .res_valid(res_valid), .res_data(res_data), .trap_valid(trap_valid),
        .trap_cause(trap_cause), .trap_tval(trap_tval), .trap_tval2(trap_tval2),
        .trap_tinst(trap_tinst), .chk_addr(chk_addr));

    int n_checks = 0, n_err = 0;
    bit done = 0;
    bit flt_lo = 0, flt_hi = 0;
    int req_cnt = 0;
    logic [31:0] log_addr [16];
    logic [1:0]  log_size [16];

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction
    function automatic logic [31:0] to_gpa(input logic [31:0] a);
        return a + GPA_OFS;
    endfunction
    function automatic bit faults(input logic [31:0] a);
        return (flt_lo && a[31:12] == 20'h1) || (flt_hi && a[31:12] == 20'h2);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: stalls ready every third cycle, answers one cycle after handshake
    initial begin
        int cyc = 0;
        bit pend = 0;
        logic [31:0] pa = '0;
        logic [1:0] ps = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            mem_rsp_fault = 0;
            if (!rst_n) begin
                pend = 0;
                mem_req_ready = 0;
                continue;
            end
            if (pend) begin
                logic [63:0] dv = '0;
                for (int i = 0; i < (1 << ps); i++) dv[i*8 +: 8] = mem_byte(pa + i);
                mem_rsp_valid = 1;
                mem_rsp_fault = faults(pa);
                mem_rsp_cause = faults(pa) ? 6'd21 : 6'd0;
                mem_rsp_gpa   = to_gpa(pa);
                mem_rsp_data  = faults(pa) ? 64'h0 : dv;
                pend = 0;
            end
            cyc++;
            mem_req_ready = (cyc % 3) != 2;
            if (mem_req_valid && mem_req_ready) begin
                if (req_cnt < 16) begin
                    log_addr[req_cnt] = mem_req_addr;
                    log_size[req_cnt] = mem_req_size;
                end
                req_cnt++;
                pa = mem_req_addr;
                ps = mem_req_size;
                pend = 1;
            end
        end
    end

    task automatic run_cmd(input logic [31:0] va, input int w, input bit s, input logic [4:0] rd);
        int n = 2 << w;
        bit mis = (va % n) != 0;
        bit exp_trap = 0;
        int off = 0;
        int exp_reqs;
        logic [63:0] val = '0;
        logic [63:0] mask;
        bit got_res = 0, got_trap = 0;
        logic [63:0] g_data = '0;
        logic [31:0] g_tval = '0, g_tval2 = '0, g_tinst = '0, g_chk = '0;
        logic [5:0] g_cause = '0;
        logic [31:0] exp_tinst;
        logic [31:0] fa;

        if (!mis) begin
            if (faults(va)) exp_trap = 1;
        end else begin
            for (int i = 0; i < n; i++) begin
                if (!exp_trap && faults(va + i)) begin
                    exp_trap = 1;
                    off = i;
                end
            end
        end
        for (int i = 0; i < n; i++) val[i*8 +: 8] = mem_byte(va + i);
        mask = (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 1);
        if (s && val[8*n-1]) val = val | ~mask;
        exp_reqs = !mis ? 1 : (exp_trap ? off + 1 : n);
        fa = va + off;
        exp_tinst = {12'b0, 5'(off), ~s, 2'(w + 1), rd, 7'h03};

        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        req_cnt = 0;
        cmd_valid = 1; cmd_vaddr = va; cmd_width = 2'(w); cmd_signed = s; cmd_rd = rd;
        @(negedge clk);
        cmd_valid = 0;
        check(!cmd_ready, "R10 busy after accept", 64'(cmd_ready), 64'd0);
        for (int t = 0; t < 100; t++) begin
            if (res_valid || trap_valid) begin
                got_res = res_valid; got_trap = trap_valid;
                g_data = res_data; g_tval = trap_tval; g_tval2 = trap_tval2;
                g_tinst = trap_tinst; g_chk = chk_addr; g_cause = trap_cause;
                break;
            end
            @(negedge clk);
        end
        check(got_trap == exp_trap && got_res == !exp_trap, "R10 outcome kind",
              {62'd0, got_trap, got_res}, {62'd0, exp_trap, !exp_trap});
        if (!exp_trap) begin
            check(g_data == val, "R4 assembled value", g_data, val);
        end else begin
            check(g_tval == fa, "R6 faulting vaddr", 64'(g_tval), 64'(fa));
            check(g_cause == 6'd21, "R6 cause", 64'(g_cause), 64'd21);
            check(g_tval2 == (to_gpa(fa) >> 2), "R7 tval2", 64'(g_tval2), 64'(to_gpa(fa) >> 2));
            check(g_tinst == exp_tinst, "R8 tinst", 64'(g_tinst), 64'(exp_tinst));
            check(g_chk == to_gpa(va), "R9 recovered address", 64'(g_chk), 64'(to_gpa(va)));
        end
        if (!mis) begin
            check(log_addr[0] == va && log_size[0] == 2'(w + 1), "R2 single request",
                  {30'd0, log_size[0], log_addr[0]}, {30'd0, 2'(w + 1), va});
        end else begin
            for (int k = 0; k < exp_reqs && k < 16; k++)
                check(log_addr[k] == va + k && log_size[k] == 2'd0, "R3 byte order",
                      {30'd0, log_size[k], log_addr[k]}, {32'd0, va + k});
        end
        // R5/R10: no extra requests or outcomes afterward
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            check(!res_valid && !trap_valid, "R10 single pulse", {62'd0, res_valid, trap_valid}, 64'd0);
        end
        check(req_cnt == exp_reqs, "R5 request count", 64'(req_cnt), 64'(exp_reqs));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready && !mem_req_valid && !res_valid && !trap_valid, "R1 reset state",
              {60'd0, cmd_ready, mem_req_valid, res_valid, trap_valid}, 64'h8);
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready && !mem_req_valid, "R1 idle after reset",
              {62'd0, cmd_ready, mem_req_valid}, 64'h2);
        for (int sc = 0; sc < 4; sc++) begin
            flt_lo = (sc == 2 || sc == 3);
            flt_hi = (sc == 1 || sc == 2);
            for (int w = 0; w < 3; w++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 16; k++)
                        run_cmd(32'h0000_1FF0 + k, w, s[0], 5'(k + w + 3));
        end
        flt_lo = 0; flt_hi = 0;
        for (int w = 0; w < 3; w++)
            for (int k = 0; k < 8; k++)
                run_cmd(32'h0000_3080 + k * 9, w, k[0], 5'd17);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule